// File: doc/BRIEF.md
# Zero-Page Load/Store Sequencer Core

This block is the control and datapath core of a very small accumulator machine. It runs two instructions: a load into the accumulator and a store from the accumulator. Both take a one-byte operand that names a location in the first 256 bytes of memory (the zero page). Any other opcode byte is consumed as a two-cycle no-operation.

The core holds an 8-bit instruction register, a program counter, a zero-page address latch, an input data latch and the accumulator. A three-bit timing counter steps through the bus cycles. A purely combinational decode network looks at the instruction register and the timing state. From those two it produces every datapath strobe and also the next timing state, so an instruction ends as soon as its work is done.

Memory sits on a synchronous bus made of an address, read data, write data and a write enable. Read data is expected in the same cycle as the address that selects it. The accumulator is brought out so that results can be observed.

Top module: `zp_seq_core`

## Requirements
- R1: A synchronous active-high reset clears the accumulator and all latches, sets the program counter to 0x0000 and puts the timing counter in the opcode-fetch state. While reset is held and in the first cycle after it, mem_addr is 0x0000, mem_we is 0 and acc_out is 0x00.
- R2: In an opcode-fetch cycle, mem_addr equals the program counter, the byte read is taken into the instruction register, and the program counter advances by one.
- R3: When the opcode is 0xA5 (load) or 0x85 (store), the cycle after the fetch puts the program counter on mem_addr, takes the byte read as the zero-page address and advances the program counter again.
- R4: The third cycle of a load drives mem_addr with the high byte 0x00 and the low byte taken from the zero-page latch, keeps mem_we at 0, and captures mem_rdata in the input data latch.
- R5: The input data latch is copied into the accumulator at the end of the next opcode-fetch cycle, in parallel with that fetch. acc_out still shows the old value during that fetch and shows the loaded value from the following cycle on, so a load takes three cycles of its own.
- R6: The third cycle of a store drives mem_addr with 0x00 and the zero-page byte, drives the accumulator on mem_wdata and asserts mem_we for exactly that one cycle. The next cycle is an opcode fetch.
- R7: Any opcode other than 0xA5 and 0x85 takes two cycles, advances the program counter by exactly one, writes nothing and leaves the accumulator unchanged.
- R8: mem_we is 0 in every cycle that is not the third cycle of a store.
- R9: A store placed right after a load writes the value that the load fetched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory address for the current cycle |
| mem_rdata | input | 8 | Read data for mem_addr, valid in the same cycle |
| mem_wdata | output | 8 | Write data (the accumulator) |
| mem_we | output | 1 | Write enable, sampled on the rising edge |
| acc_out | output | 8 | Current accumulator value |

## Verification
The bench targets the overlap of a load's accumulator write with the next fetch. A core that wrote the accumulator one cycle early or late would show a wrong acc_out in the fetch cycle or in the cycle after it. A store placed directly after a load would then write stale data. Other corner cases are no-operation opcodes, which would desynchronise every later fetch address if they consumed an operand byte, and a reset taken in the middle of an instruction, which must not leave a write pending or keep the accumulator. At the end, zero-page memory is compared with a model, which catches a write enable held for more than one cycle or sent to the wrong address.

// File: rtl/zp_seq_pkg.sv
package zp_seq_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;
    localparam int TIM_W  = 3;

    localparam logic [7:0] OPC_LOAD  = 8'hA5;
    localparam logic [7:0] OPC_STORE = 8'h85;

    // timing states of the bus sequencer
    typedef enum logic [TIM_W-1:0] {
        TS_FETCH = 3'd0,
        TS_OPER  = 3'd1,
        TS_EXEC  = 3'd2
    } tstate_e;

    // strobes produced by the decode network for one cycle
    typedef struct packed {
        logic    ir_ld;
        logic    pc_inc;
        logic    zp_ld;
        logic    din_ld;
        logic    acc_from_din;
        logic    mem_wr;
        logic    addr_zp;
        tstate_e next_ts;
    } ctrl_s;

    function automatic logic is_load(input logic [7:0] op);
        return op == OPC_LOAD;
    endfunction

    function automatic logic is_store(input logic [7:0] op);
        return op == OPC_STORE;
    endfunction

    function automatic logic takes_operand(input logic [7:0] op);
        return is_load(op) || is_store(op);
    endfunction

endpackage

// File: rtl/zp_decode.sv
module zp_decode
    import zp_seq_pkg::*;
(
    input  tstate_e    ts,
    input  logic [7:0] ir,
    output ctrl_s      ctl
);

    // Mealy network: strobes and next timing state from (ir, ts)
    always_comb begin
        ctl         = '0;
        ctl.next_ts = TS_FETCH;
        case (ts)
            TS_FETCH: begin
                // ir still holds the previous opcode here: finish a load
                ctl.ir_ld        = 1'b1;
                ctl.pc_inc       = 1'b1;
                ctl.acc_from_din = is_load(ir);
                ctl.next_ts      = TS_OPER;
            end
            TS_OPER: begin
                if (takes_operand(ir)) begin
                    ctl.zp_ld   = 1'b1;
                    ctl.pc_inc  = 1'b1;
                    ctl.next_ts = TS_EXEC;
                end
            end
            TS_EXEC: begin
                ctl.addr_zp = 1'b1;
                ctl.din_ld  = is_load(ir);
                ctl.mem_wr  = is_store(ir);
            end
            default: ctl.next_ts = TS_FETCH;
        endcase
    end

endmodule

// File: rtl/zp_datapath.sv
module zp_datapath
    import zp_seq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  ctrl_s         ctl,
    input  logic [DW-1:0] rdata,
    output logic [7:0]    ir,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] acc
);

    localparam int HI_W = AW - DW;

    logic [7:0]    ir_q;
    logic [AW-1:0] pc_q;
    logic [DW-1:0] zp_q;
    logic [DW-1:0] din_q;
    logic [DW-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q  <= '0;
            pc_q  <= '0;
            zp_q  <= '0;
            din_q <= '0;
            acc_q <= '0;
        end else begin
            if (ctl.ir_ld)        ir_q  <= rdata[7:0];
            if (ctl.pc_inc)       pc_q  <= pc_q + AW'(1);
            if (ctl.zp_ld)        zp_q  <= rdata;
            if (ctl.din_ld)       din_q <= rdata;
            if (ctl.acc_from_din) acc_q <= din_q;
        end
    end

    // zero-page cycles force the high address byte to zero
    assign addr  = ctl.addr_zp ? {{HI_W{1'b0}}, zp_q} : pc_q;
    assign wdata = acc_q;
    assign ir    = ir_q;
    assign acc   = acc_q;

    assert_din_capture_R4: assert property (@(posedge clk) disable iff (rst)
        ctl.din_ld |=> (din_q == $past(rdata)));

    assert_acc_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !ctl.acc_from_din |=> $stable(acc_q));

endmodule

// File: rtl/zp_seq_core.sv
module zp_seq_core
    import zp_seq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic [DW-1:0] acc_out
);

    tstate_e    ts_q;
    ctrl_s      ctl;
    logic [7:0] ir;

    // timing counter, advanced by the decode's own next-state choice
    always_ff @(posedge clk) begin
        if (rst) ts_q <= TS_FETCH;
        else     ts_q <= ctl.next_ts;
    end

    zp_decode u_dec (
        .ts  (ts_q),
        .ir  (ir),
        .ctl (ctl)
    );

    zp_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .rdata (mem_rdata),
        .ir    (ir),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .acc   (acc_out)
    );

    assign mem_we = ctl.mem_wr;

    assert_ts_legal_R1: assert property (@(posedge clk) disable iff (rst)
        (ts_q == TS_FETCH) || (ts_q == TS_OPER) || (ts_q == TS_EXEC));

    assert_fetch_step_R2: assert property (@(posedge clk) disable iff (rst)
        (ts_q == TS_FETCH) |=> (mem_addr == $past(mem_addr) + AW'(1)));

    assert_zp_high_R4: assert property (@(posedge clk) disable iff (rst)
        (ts_q == TS_EXEC) |-> (mem_addr[AW-1:DW] == '0));

    assert_we_exec_R8: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (ts_q == TS_EXEC));

    assert_we_once_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (!mem_we && ts_q == TS_FETCH));

    assert_nop_len_R7: assert property (@(posedge clk) disable iff (rst)
        (ts_q == TS_OPER && !takes_operand(ir)) |=> (ts_q == TS_FETCH));

endmodule

// File: tb/sim_zp_seq_core.sv
module sim_zp_seq_core;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fill = 1'b1;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  acc_out;

    logic [7:0] mem     [256];
    logic [7:0] img     [256];
    logic [7:0] exp_mem [256];

    int n_chk  = 0;
    int n_fail = 0;
    int n_instr = 0;

    logic [7:0] m_pc, m_acc, m_pend;
    bit         m_pend_v;
    bit         prev_load;

    always #(CLK_PERIOD/2) clk = ~clk;

    zp_seq_core u0 (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .acc_out   (acc_out)
    );

    // bench memory: 256 bytes, combinational read
    always @(posedge clk) begin
        if (fill)        mem <= img;
        else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end
    assign mem_rdata = mem[mem_addr[7:0]];

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp_v);
        end
    endtask

    // called positioned at the negedge inside a fetch cycle
    task automatic run_one();
        logic [7:0] op, zp;
        chk(mem_addr == {8'h00, m_pc}, "R2 fetch address", mem_addr, {8'h00, m_pc});
        chk(!mem_we, "R8 no write in fetch", mem_we, 0);
        chk(acc_out == m_acc, "R5 acc still old during fetch", acc_out, m_acc);
        op = exp_mem[m_pc];
        m_pc++;
        if (m_pend_v) m_acc = m_pend;
        m_pend_v = 0;
        @(negedge clk);
        chk(acc_out == m_acc, "R5 acc after overlapped write", acc_out, m_acc);
        if (op == 8'hA5 || op == 8'h85) begin
            chk(mem_addr == {8'h00, m_pc}, "R3 operand address", mem_addr, {8'h00, m_pc});
            chk(!mem_we, "R8 no write in operand cycle", mem_we, 0);
            zp = exp_mem[m_pc];
            m_pc++;
            @(negedge clk);
            chk(mem_addr == {8'h00, zp}, "R4 R6 zero-page address", mem_addr, {8'h00, zp});
            if (op == 8'hA5) begin
                chk(!mem_we, "R4 no write on load", mem_we, 0);
                m_pend   = exp_mem[zp];
                m_pend_v = 1;
            end else begin
                chk(mem_we, "R6 write enable in third cycle", mem_we, 1);
                if (prev_load)
                    chk(mem_wdata == m_acc, "R9 store after load data", mem_wdata, m_acc);
                else
                    chk(mem_wdata == m_acc, "R6 store data", mem_wdata, m_acc);
                exp_mem[zp] = m_acc;
            end
        end else begin
            chk(!mem_we, "R7 no write on other opcode", mem_we, 0);
        end
        prev_load = (op == 8'hA5);
        @(negedge clk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1 act=%0d exp=0", WD_CYCLES);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int p;
        logic [7:0] op;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 256; i++)
            img[i] = (i >= 128) ? 8'($urandom) : 8'h00;
        // directed prefix: load, store after load, nop, readback, load-load, store
        img[0]  = 8'hA5; img[1]  = 8'h80;
        img[2]  = 8'h85; img[3]  = 8'h81;
        img[4]  = 8'hEA;
        img[5]  = 8'hA5; img[6]  = 8'h81;
        img[7]  = 8'hA5; img[8]  = 8'h82;
        img[9]  = 8'h85; img[10] = 8'h83;
        n_instr = 6;
        p = 11;
        while (p < 8'h76) begin
            case ($urandom % 4)
                0, 1: begin
                    img[p] = 8'hA5; img[p+1] = 8'h80 | 8'($urandom % 128); p += 2;
                end
                2: begin
                    img[p] = 8'h85; img[p+1] = 8'h80 | 8'($urandom % 128); p += 2;
                end
                default: begin
                    op = 8'($urandom);
                    while (op == 8'hA5 || op == 8'h85) op = 8'($urandom);
                    img[p] = op; p += 1;
                end
            endcase
            n_instr++;
        end
        exp_mem = img;
        m_pc = 0; m_acc = 0; m_pend = 0; m_pend_v = 0; prev_load = 0;

        // R1: reset state
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(mem_addr == 16'h0000, "R1 reset address", mem_addr, 0);
        chk(!mem_we, "R1 reset write enable", mem_we, 0);
        chk(acc_out == 8'h00, "R1 reset accumulator", acc_out, 0);
        rst  = 1'b0;
        fill = 1'b0;

        for (int k = 0; k < n_instr; k++) run_one();

        // R6: every store landed exactly where the model put it
        for (int a = 128; a < 256; a++)
            chk(mem[a] == exp_mem[a], "R6 zero-page memory image", mem[a], exp_mem[a]);

        // R1: reset taken in the middle of an instruction
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(mem_addr == 16'h0000, "R1 mid-run reset address", mem_addr, 0);
        chk(!mem_we, "R1 mid-run reset write enable", mem_we, 0);
        chk(acc_out == 8'h00, "R1 mid-run reset accumulator", acc_out, 0);
        rst = 1'b0;
        m_pc = 0; m_acc = 0; m_pend_v = 0; prev_load = 0;
        run_one();
        run_one();
        run_one();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule